// File: doc/BRIEF.md
# Multi-Plane Page Interleave Sequencer

This block turns one page of a wide logical allocation unit into one physical page-program target. A logical unit is striped over eight physical blocks: the two planes of a programmable plane pair, the two banks of a chip, and two chips. The unit holds 1024 data pages. Each physical block holds 128 pages of 2112 bytes, made of 2048 data bytes and 64 spare bytes. Consecutive logical pages therefore move first across the plane pair, then across banks, then across chips. Only after all eight lanes have been used does the physical page number advance.

A request carries a page offset within the logical unit and a pair selector. The pair selector picks planes {0,1} or planes {2,3}. A separate bus supplies the block-within-plane number for each of the eight lanes. The block samples that bus when it accepts a request and emits one command beat. The beat carries the chip, bank, plane, bank-wide block number, page, and a flag that closes a dual-plane pair.

Both streams use valid/ready. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. The command beat appears on the next cycle. The beat holds all of its fields steady while `cmd_ready` is low. `req_ready` stays low from the moment a beat is presented until the edge at which that beat is accepted. An offset outside the unit produces a one-cycle error pulse and no beat.

Top module: `page_ilv_seq`

## Requirements
- R1: After reset, `cmd_valid` and `err` are 0 and `req_ready` is 1.
- R2: The output plane is {`req_pair`, offset bit 0}. Pair 0 gives planes 0/1 and pair 1 gives planes 2/3.
- R3: Offset bit 1 gives `cmd_bank` and offset bit 2 gives `cmd_chip`.
- R4: Offset bits 9:3 give `cmd_page` (0..127).
- R5: The lane index is offset bits 2:0. The lane's block-within-plane number is found at bits [lane*11 +: 11] of `lane_blk`, as sampled at the accepting edge. `cmd_blk` is that number with the 2-bit plane appended below it, so that even and odd blocks alternate inside a pair.
- R6: `cmd_mp` is 1 exactly on the odd plane of the pair (offset bit 0 = 1). This marks the beat that completes a dual-plane program.
- R7: An accepted offset of 1024 or more raises `err` for the following cycle only, and no beat is produced.
- R8: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid` and every command field stay unchanged.
- R9: `req_ready` is 0 while a beat is pending. A request offered during that time is not taken.
- R10: A beat appears one cycle after its request is accepted. `cmd_valid` drops in the cycle after the accepting edge, unless a new request was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_pair | input | 1 | Plane pair select (0: planes 0/1, 1: planes 2/3) |
| req_off | input | 12 | Page offset within the logical unit |
| lane_blk | input | 88 | Eight 11-bit block-within-plane numbers, lane 0 in the low bits |
| cmd_valid | output | 1 | Command beat present |
| cmd_ready | input | 1 | Command beat accepted |
| cmd_chip | output | 1 | Target chip |
| cmd_bank | output | 1 | Target bank within the chip |
| cmd_plane | output | 2 | Target plane |
| cmd_blk | output | 13 | Bank-wide physical block number |
| cmd_page | output | 7 | Page within the physical block |
| cmd_mp | output | 1 | Closes a dual-plane pair |
| err | output | 1 | Out-of-range request pulse |

## Verification
A wrong lane decode shows up at once on the first beat. The block number comes from the wrong slot of `lane_blk`, or the chip, bank or plane fields disagree with the offset, one cycle after the request is accepted. A broken hold register shows up during back-pressure: a field changes, or `cmd_valid` drops, before `cmd_ready` rises. A broken busy flag shows up as a second request being taken while a beat is still pending. A faulty range check shows up as a beat, or as a missing `err` pulse, one cycle after an offset of 1024 or more.

// File: rtl/ipil_pkg.sv
package ipil_pkg;
  // lane index bits inside the page offset; order is the interleave order
  localparam int PLANE_SEL_BIT = 0;
  localparam int BANK_SEL_BIT  = 1;
  localparam int CHIP_SEL_BIT  = 2;
  localparam int LANE_W        = 3;
  localparam int LANES         = 1 << LANE_W;
endpackage

// File: rtl/ipil_decode.sv
module ipil_decode
  import ipil_pkg::*;
#(
  parameter int OFF_IN_W = 12,
  parameter int PG_W     = 7,
  parameter int BLK_W    = 11
) (
  input  logic                     pair,
  input  logic [OFF_IN_W-1:0]      off,
  input  logic [LANES*BLK_W-1:0]   lane_blk,
  output logic                     chip,
  output logic                     bank,
  output logic [1:0]               plane,
  output logic [BLK_W+1:0]         pblk,
  output logic [PG_W-1:0]          page,
  output logic                     mp,
  output logic                     bad
);
  localparam int OFF_W = PG_W + LANE_W;

  logic [BLK_W-1:0]  blk_tab [LANES];
  logic [LANE_W-1:0] lane;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign blk_tab[g] = lane_blk[g*BLK_W +: BLK_W];
    end
    if (OFF_IN_W > OFF_W) begin : g_rng
      assign bad = |off[OFF_IN_W-1:OFF_W];
    end else begin : g_norng
      assign bad = 1'b0;
    end
  endgenerate

  always_comb begin
    lane  = off[LANE_W-1:0];
    plane = {pair, off[PLANE_SEL_BIT]};
    bank  = off[BANK_SEL_BIT];
    chip  = off[CHIP_SEL_BIT];
    page  = off[OFF_W-1:LANE_W];
    pblk  = {blk_tab[lane], plane};
    mp    = off[PLANE_SEL_BIT];
  end
endmodule

// File: rtl/ipil_hold.sv
module ipil_hold #(
  parameter int PG_W  = 7,
  parameter int PBK_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             bad,
  input  logic             d_chip,
  input  logic             d_bank,
  input  logic [1:0]       d_plane,
  input  logic [PBK_W-1:0] d_blk,
  input  logic [PG_W-1:0]  d_page,
  input  logic             d_mp,
  input  logic             cmd_ready,
  output logic             cmd_valid,
  output logic             cmd_chip,
  output logic             cmd_bank,
  output logic [1:0]       cmd_plane,
  output logic [PBK_W-1:0] cmd_blk,
  output logic [PG_W-1:0]  cmd_page,
  output logic             cmd_mp,
  output logic             err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      err       <= 1'b0;
      cmd_chip  <= 1'b0;
      cmd_bank  <= 1'b0;
      cmd_plane <= '0;
      cmd_blk   <= '0;
      cmd_page  <= '0;
      cmd_mp    <= 1'b0;
    end else begin
      err <= take & bad;
      if (take && !bad) begin
        cmd_valid <= 1'b1;
        cmd_chip  <= d_chip;
        cmd_bank  <= d_bank;
        cmd_plane <= d_plane;
        cmd_blk   <= d_blk;
        cmd_page  <= d_page;
        cmd_mp    <= d_mp;
      end else if (cmd_valid && cmd_ready) begin
        cmd_valid <= 1'b0;
      end
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_blk) && $stable(cmd_page)
      && $stable(cmd_plane) && $stable(cmd_chip) && $stable(cmd_bank) && $stable(cmd_mp));

  // R7
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && bad |=> err && !cmd_valid);

  // R10
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !take |=> !cmd_valid);
endmodule

// File: rtl/page_ilv_seq.sv
module page_ilv_seq
  import ipil_pkg::*;
#(
  parameter int PAGES_PER_BLK  = 128,
  parameter int BLKS_PER_PLANE = 2048,
  parameter int OFF_IN_W       = 12,
  localparam int PG_W  = $clog2(PAGES_PER_BLK),
  localparam int BLK_W = $clog2(BLKS_PER_PLANE),
  localparam int PBK_W = BLK_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_pair,
  input  logic [OFF_IN_W-1:0]    req_off,
  input  logic [LANES*BLK_W-1:0] lane_blk,
  output logic                   cmd_valid,
  input  logic                   cmd_ready,
  output logic                   cmd_chip,
  output logic                   cmd_bank,
  output logic [1:0]             cmd_plane,
  output logic [PBK_W-1:0]       cmd_blk,
  output logic [PG_W-1:0]        cmd_page,
  output logic                   cmd_mp,
  output logic                   err
);
  logic             take, bad, d_chip, d_bank, d_mp;
  logic [1:0]       d_plane;
  logic [PBK_W-1:0] d_blk;
  logic [PG_W-1:0]  d_page;

  assign req_ready = ~cmd_valid;
  assign take      = req_valid & req_ready;

  ipil_decode #(.OFF_IN_W(OFF_IN_W), .PG_W(PG_W), .BLK_W(BLK_W)) u_dec (
    .pair(req_pair), .off(req_off), .lane_blk(lane_blk),
    .chip(d_chip), .bank(d_bank), .plane(d_plane), .pblk(d_blk),
    .page(d_page), .mp(d_mp), .bad(bad)
  );

  ipil_hold #(.PG_W(PG_W), .PBK_W(PBK_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .take(take), .bad(bad),
    .d_chip(d_chip), .d_bank(d_bank), .d_plane(d_plane), .d_blk(d_blk),
    .d_page(d_page), .d_mp(d_mp), .cmd_ready(cmd_ready),
    .cmd_valid(cmd_valid), .cmd_chip(cmd_chip), .cmd_bank(cmd_bank),
    .cmd_plane(cmd_plane), .cmd_blk(cmd_blk), .cmd_page(cmd_page),
    .cmd_mp(cmd_mp), .err(err)
  );

  // R4
  page_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !bad |=> cmd_valid && cmd_page == $past(req_off[PG_W+LANE_W-1:LANE_W]));

  // R2
  plane_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !bad |=> cmd_plane == {$past(req_pair), $past(req_off[PLANE_SEL_BIT])});
endmodule

// File: tb/sim_page_ilv_seq.sv
module sim_page_ilv_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_pair = 1'b0, cmd_ready = 1'b0;
  logic [11:0] req_off = '0;
  logic [87:0] lane_blk = '0;
  logic        req_ready, cmd_valid, cmd_chip, cmd_bank, cmd_mp, err;
  logic [1:0]  cmd_plane;
  logic [12:0] cmd_blk;
  logic [6:0]  cmd_page;
  int total = 0, bad = 0;
  logic [10:0] lanes [8];

  always #10 clk = ~clk;

  page_ilv_seq u0 (.*);

  task automatic chk(string rq, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic set_lanes(int seed);
    for (int i = 0; i < 8; i++) begin
      lanes[i] = 11'((seed + i * 37) & 11'h7ff);
      lane_blk[i*11 +: 11] = lanes[i];
    end
  endtask

  // offer a request at a negedge, taken at the following posedge
  task automatic offer(logic p, int off);
    @(negedge clk);
    req_valid = 1'b1; req_pair = p; req_off = 12'(off);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic expect_beat(logic p, int off, string tag);
    @(negedge clk);
    chk({tag, " R10 valid"}, cmd_valid, 1);
    chk({tag, " R2 plane"}, cmd_plane, {p, off[0]});
    chk({tag, " R3 bank"}, cmd_bank, off[1]);
    chk({tag, " R3 chip"}, cmd_chip, off[2]);
    chk({tag, " R4 page"}, cmd_page, (off >> 3) & 127);
    chk({tag, " R5 blk"}, cmd_blk, {lanes[off & 7], p, off[0]});
    chk({tag, " R6 mp"}, cmd_mp, off[0]);
    chk({tag, " R9 busy"}, req_ready, 0);
    cmd_ready = 1'b1;
    @(posedge clk); #1;
    cmd_ready = 1'b0;
    @(negedge clk);
    chk({tag, " R10 drop"}, cmd_valid, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 valid", cmd_valid, 0);
    chk("R1 err", err, 0);
    chk("R1 ready", req_ready, 1);
  endtask

  task automatic t_lanes();
    set_lanes(100);
    for (int o = 0; o < 8; o++) begin
      offer(0, o); expect_beat(0, o, "lanes p0");
    end
    set_lanes(700);
    for (int o = 16; o < 24; o++) begin
      offer(1, o); expect_beat(1, o, "lanes p1");
    end
  endtask

  task automatic t_pages();
    set_lanes(1500);
    offer(1, 1023); expect_beat(1, 1023, "last page");
    offer(0, 8);    expect_beat(0, 8, "page1");
    offer(0, 517);  expect_beat(0, 517, "mid");
  endtask

  task automatic t_backpressure();
    set_lanes(33);
    offer(0, 300);
    set_lanes(900);  // sampled value must remain
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      req_valid = 1'b1; req_off = 12'd5;
      chk("R8 held valid", cmd_valid, 1);
      chk("R8 held page", cmd_page, 300 >> 3);
      chk("R8 held blk", cmd_blk, {11'((33 + 4 * 37) & 11'h7ff), 1'b0, 1'b0});
      chk("R9 not ready", req_ready, 0);
    end
    req_valid = 1'b0;
    cmd_ready = 1'b1;
    @(posedge clk); #1;
    cmd_ready = 1'b0;
    @(negedge clk);
    chk("R9 no extra beat", cmd_valid, 0);
    chk("R10 ready back", req_ready, 1);
  endtask

  task automatic t_range();
    offer(0, 1024);
    @(negedge clk);
    chk("R7 err 1024", err, 1);
    chk("R7 no beat", cmd_valid, 0);
    @(negedge clk);
    chk("R7 err pulse", err, 0);
    offer(1, 4095);
    @(negedge clk);
    chk("R7 err max", err, 1);
    chk("R7 no beat max", cmd_valid, 0);
    set_lanes(5);
    offer(0, 3); expect_beat(0, 3, "after err");
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    set_lanes(0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_lanes();
    t_pages();
    t_backpressure();
    t_range();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule